// File: doc/BRIEF.md
# Dual-Stream Frame Assembler

This block merges two independently timed byte streams into fixed-layout 64-byte frames. Each stream arrives with its own valid strobe. The block collects 24 payload bytes from each stream. When a frame is sent, four bytes from a header input lead the frame, the two payload segments follow, and a constant fill byte pads the tail.

Frames are double-buffered. While one complete frame waits for its turn or streams out, the next one is assembled in the other bank. A refill request from the downstream frame-position logic starts a burst of 64 consecutive FIFO writes. The burst pauses while the FIFO reports full, and it resumes without losing or repeating a byte.

A request that finds no complete frame is skipped, and a sticky flag records it. A request that arrives during a burst is ignored.

Top module: `frame_merge_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `fifo_wr` and `not_ready` are 0.
- R2: Frame positions 4 to 27 carry the first 24 accepted `a_data` bytes of that frame, in arrival order.
- R3: Frame positions 28 to 51 carry the first 24 accepted `b_data` bytes of that frame, in arrival order.
- R4: Frame position k (0 to 3) carries `hdr_in[8k+7:8k]`, sampled on the clock edge that accepts the refill request.
- R5: Frame positions 52 to 63 carry the fill value 0xA5.
- R6: A refill request accepted while a frame is ready produces exactly 64 writes on `fifo_wr`, in position order 0 to 63. The first write can happen in the cycle after the accepting edge.
- R7: In any cycle where `fifo_full` is 1, `fifo_wr` is 0. Writes resume when `fifo_full` falls, and no byte is dropped or repeated.
- R8: Bytes for the next frame are accepted into the second bank while the previous frame is ready or being sent.
- R9: A refill request that arrives with no ready frame and no burst in progress causes no write and sets `not_ready` to 1. Only reset clears `not_ready`.
- R10: A refill request that arrives during a burst causes no extra write and leaves `not_ready` unchanged.
- R11: A byte that arrives for a segment already holding 24 bytes is discarded. It appears in neither the current frame nor the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Stream A byte strobe |
| a_data | input | 8 | Stream A byte |
| b_valid | input | 1 | Stream B byte strobe |
| b_data | input | 8 | Stream B byte |
| hdr_in | input | 32 | Header bytes, byte k at bits 8k+7:8k |
| refill_req | input | 1 | One-cycle frame refill request |
| fifo_full | input | 1 | Downstream FIFO full flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write byte |
| not_ready | output | 1 | Sticky flag for a skipped request |

## Verification
The bench tries several input patterns:
- Random interleavings and gaps on the two streams check that each segment keeps its own arrival order. They also check that neither segment borrows bytes from the other.
- Random full-flag toggling during bursts checks the stall logic. A directed 12-cycle full hold checks that the burst keeps its position across a long stall.
- Feeding the next frame during a burst checks the double buffering.
- A surplus stream-A byte checks that an over-long segment is discarded.
- A refill request issued mid-burst must start no second burst.
- A request issued with nothing ready must set the flag and write nothing. A later frame then shows that the flag stays set.

// File: rtl/fm_pkg.sv
// Shared types for the dual-stream frame assembler.
package fm_pkg;

    // Source of the byte at a given frame position
    typedef enum logic [1:0] {
        SLOT_HDR  = 2'd0,
        SLOT_SEGA = 2'd1,
        SLOT_SEGB = 2'd2,
        SLOT_FILL = 2'd3
    } slot_e;

endpackage

// File: rtl/fm_seg_collect.sv
// Segment collector: counts the accepted bytes of one stream into a segment
// of SEG_LEN bytes and produces the write index for the frame store.
// Assumes: clear is pulsed only when the segment has been handed over.
// Bytes arriving while the segment is full are discarded.
module fm_seg_collect #(
    parameter int DW      = 8,
    parameter int SEG_LEN = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [DW-1:0]              in_data,
    input  logic                       clear,
    output logic                       wr_en,
    output logic [$clog2(SEG_LEN)-1:0] wr_idx,
    output logic [DW-1:0]              wr_data,
    output logic                       full
);
    localparam int CNT_W = $clog2(SEG_LEN + 1);
    localparam int IDX_W = $clog2(SEG_LEN);

    logic [CNT_W-1:0] cnt;

    // Accept a byte only while the segment has room
    assign full    = (cnt == CNT_W'(SEG_LEN));
    assign wr_en   = in_valid & ~full;
    assign wr_idx  = IDX_W'(cnt);
    assign wr_data = in_data;

    // Byte counter, restarted when the segment is handed over
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (wr_en) cnt <= cnt + 1'b1;
    end

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(SEG_LEN));

    // R11
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !clear |=> full);

    // R2
    seg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !clear |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/fm_frame_store.sv
// Frame store: two banks, each holding one payload segment per stream.
// Header and fill bytes are not stored. Writes go to bank wr_bank and reads
// come from bank rd_bank through a combinational port.
// Assumes: the controller never reads and writes the same bank at once.
// The storage has no reset, because no byte is read before it is written.
module fm_frame_store #(
    parameter int DW      = 8,
    parameter int SEG_LEN = 24
) (
    input  logic                       clk,
    input  logic                       wr_bank,
    input  logic                       a_we,
    input  logic [$clog2(SEG_LEN)-1:0] a_idx,
    input  logic [DW-1:0]              a_data,
    input  logic                       b_we,
    input  logic [$clog2(SEG_LEN)-1:0] b_idx,
    input  logic [DW-1:0]              b_data,
    input  logic                       rd_bank,
    input  logic                       rd_seg,
    input  logic [$clog2(SEG_LEN)-1:0] rd_idx,
    output logic [DW-1:0]              rd_data
);
    localparam int NBANK = 2;

    logic [DW-1:0] bank_rd [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [DW-1:0] seg_a [SEG_LEN];
        logic [DW-1:0] seg_b [SEG_LEN];

        // Store incoming stream bytes into this bank when it is selected
        always_ff @(posedge clk) begin
            if (a_we && (wr_bank == 1'(g))) seg_a[a_idx] <= a_data;
            if (b_we && (wr_bank == 1'(g))) seg_b[b_idx] <= b_data;
        end

        assign bank_rd[g] = rd_seg ? seg_b[rd_idx] : seg_a[rd_idx];
    end

    assign rd_data = bank_rd[rd_bank];

endmodule

// File: rtl/fm_burst_out.sv
// Burst sender: on start, latches the header and walks frame positions
// 0..FRAME_LEN-1. It issues one FIFO write per cycle while the FIFO is not
// full. Each position is mapped to header, segment A, segment B or fill.
// Assumes: start is raised only while idle and a frame is ready.
// The segment ranges lie inside the frame and do not overlap the header.
module fm_burst_out
    import fm_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          FRAME_LEN = 64,
    parameter int          SEG_LEN   = 24,
    parameter int          HDR_LEN   = 4,
    parameter int          SEGA_OFS  = 4,
    parameter int          SEGB_OFS  = 28,
    parameter logic [7:0]  FILL_BYTE = 8'hA5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [HDR_LEN*DW-1:0]      hdr_in,
    input  logic                       fifo_full,
    input  logic [DW-1:0]              rd_data,
    output logic                       busy,
    output logic                       rd_seg,
    output logic [$clog2(SEG_LEN)-1:0] rd_idx,
    output logic                       fifo_wr,
    output logic [DW-1:0]              fifo_data
);
    localparam int POS_W = $clog2(FRAME_LEN);
    localparam int IDX_W = $clog2(SEG_LEN);
    localparam int HDR_W = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0]      pos;
    logic [HDR_LEN*DW-1:0] hdr_q;
    logic [DW-1:0]         hdr_byte [HDR_LEN];
    logic [POS_W-1:0]      seg_ofs;
    slot_e                 slot;

    for (genvar g = 0; g < HDR_LEN; g++) begin : g_hdr
        assign hdr_byte[g] = hdr_q[g*DW +: DW];
    end

    // Classify the current position and derive the segment offset
    always_comb begin
        slot    = SLOT_FILL;
        seg_ofs = '0;
        if (int'(pos) < HDR_LEN) begin
            slot = SLOT_HDR;
        end else if (int'(pos) >= SEGA_OFS && int'(pos) < SEGA_OFS + SEG_LEN) begin
            slot    = SLOT_SEGA;
            seg_ofs = pos - POS_W'(SEGA_OFS);
        end else if (int'(pos) >= SEGB_OFS && int'(pos) < SEGB_OFS + SEG_LEN) begin
            slot    = SLOT_SEGB;
            seg_ofs = pos - POS_W'(SEGB_OFS);
        end
    end

    assign rd_seg = (slot == SLOT_SEGB);
    assign rd_idx = IDX_W'(seg_ofs);

    // Select the outgoing byte by slot
    always_comb begin
        case (slot)
            SLOT_HDR:  fifo_data = hdr_byte[HDR_W'(pos)];
            SLOT_SEGA: fifo_data = rd_data;
            SLOT_SEGB: fifo_data = rd_data;
            default:   fifo_data = FILL_BYTE;
        endcase
    end

    assign fifo_wr = busy & ~fifo_full;

    // Burst state: latch header on start, advance position on each write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            pos   <= '0;
            hdr_q <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            pos   <= '0;
            hdr_q <= hdr_in;
        end else if (fifo_wr) begin
            if (pos == LAST_POS) busy <= 1'b0;
            pos <= pos + 1'b1;
        end
    end

    // R6
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && (pos == '0));

    // R6
    burst_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr && (pos != LAST_POS) |=> busy && (pos == $past(pos) + 1'b1));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && fifo_full |=> busy && $stable(pos));

    // R4
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hdr_q));

endmodule

// File: rtl/frame_merge_top.sv
// Dual-stream frame assembler top. Two segment collectors fill the assembly
// bank. When both segments are full and the other bank is free, the banks
// swap and the finished frame becomes ready. A refill request then starts
// a burst of the ready frame into the FIFO.
// Assumes: refill_req is a single-cycle pulse.
// Assumes: fifo_full is valid in the cycle it is sampled.
module frame_merge_top #(
    parameter int          DW        = 8,
    parameter int          FRAME_LEN = 64,
    parameter int          SEG_LEN   = 24,
    parameter int          HDR_LEN   = 4,
    parameter int          SEGA_OFS  = 4,
    parameter int          SEGB_OFS  = 28,
    parameter logic [7:0]  FILL_BYTE = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  a_valid,
    input  logic [DW-1:0]         a_data,
    input  logic                  b_valid,
    input  logic [DW-1:0]         b_data,
    input  logic [HDR_LEN*DW-1:0] hdr_in,
    input  logic                  refill_req,
    input  logic                  fifo_full,
    output logic                  fifo_wr,
    output logic [DW-1:0]         fifo_data,
    output logic                  not_ready
);
    localparam int IDX_W = $clog2(SEG_LEN);

    logic             a_we, b_we, a_full, b_full;
    logic [IDX_W-1:0] a_idx, b_idx, rd_idx;
    logic [DW-1:0]    a_wdata, b_wdata, rd_data;
    logic             wr_sel, ready, busy, rd_seg;
    logic             complete, swap, start, skip;

    assign complete = a_full & b_full;
    assign swap     = complete & ~ready & ~busy;
    assign start    = refill_req & ready & ~busy;
    assign skip     = refill_req & ~ready & ~busy;

    fm_seg_collect #(.DW(DW), .SEG_LEN(SEG_LEN)) u_col_a (
        .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_data(a_data),
        .clear(swap), .wr_en(a_we), .wr_idx(a_idx), .wr_data(a_wdata),
        .full(a_full)
    );

    fm_seg_collect #(.DW(DW), .SEG_LEN(SEG_LEN)) u_col_b (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_data(b_data),
        .clear(swap), .wr_en(b_we), .wr_idx(b_idx), .wr_data(b_wdata),
        .full(b_full)
    );

    fm_frame_store #(.DW(DW), .SEG_LEN(SEG_LEN)) u_store (
        .clk(clk), .wr_bank(wr_sel),
        .a_we(a_we), .a_idx(a_idx), .a_data(a_wdata),
        .b_we(b_we), .b_idx(b_idx), .b_data(b_wdata),
        .rd_bank(~wr_sel), .rd_seg(rd_seg), .rd_idx(rd_idx),
        .rd_data(rd_data)
    );

    fm_burst_out #(
        .DW(DW), .FRAME_LEN(FRAME_LEN), .SEG_LEN(SEG_LEN), .HDR_LEN(HDR_LEN),
        .SEGA_OFS(SEGA_OFS), .SEGB_OFS(SEGB_OFS), .FILL_BYTE(FILL_BYTE)
    ) u_burst (
        .clk(clk), .rst_n(rst_n), .start(start), .hdr_in(hdr_in),
        .fifo_full(fifo_full), .rd_data(rd_data), .busy(busy),
        .rd_seg(rd_seg), .rd_idx(rd_idx), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data)
    );

    // Bank control: swap on completion, clear ready on burst start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel <= 1'b0;
            ready  <= 1'b0;
        end else if (swap) begin
            wr_sel <= ~wr_sel;
            ready  <= 1'b1;
        end else if (start) begin
            ready  <= 1'b0;
        end
    end

    // Sticky flag for requests that found nothing to send
    always_ff @(posedge clk) begin
        if (!rst_n)    not_ready <= 1'b0;
        else if (skip) not_ready <= 1'b1;
    end

    // R9
    notready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && !ready && !busy |=> not_ready);

    // R9
    notready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_ready |=> not_ready);

    // R10
    busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req && busy |=> $stable(not_ready) && busy);

    // R8
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || ready) |=> $stable(wr_sel));

    // R7
    full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);

endmodule

// File: tb/frame_merge_top_bench.sv
module frame_merge_top_bench;
    localparam int NF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 1'b0, b_valid = 1'b0;
    logic [7:0]  a_data = '0, b_data = '0;
    logic [31:0] hdr_in = '0;
    logic        refill_req = 1'b0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr;
    logic [7:0]  fifo_data;
    logic        not_ready;

    int checks = 0;
    int fails  = 0;
    int full_mode = 0;      // 0 never full, 1 random, 2 forced full
    logic [7:0] src_a [NF][24];
    logic [7:0] src_b [NF][24];
    logic [7:0] cap [1024];
    int cap_n = 0;

    always #10 clk = ~clk;  // 50 MHz

    frame_merge_top u_frame_merge_top (
        .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_data(a_data),
        .b_valid(b_valid), .b_data(b_data), .hdr_in(hdr_in),
        .refill_req(refill_req), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .not_ready(not_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // FIFO model: capture every write; check R7 on stalled cycles
    always @(posedge clk) begin
        if (rst_n) begin
            if (fifo_full) chk(!fifo_wr, "R7", "write while full", int'(fifo_wr), 0);
            if (fifo_wr) begin
                if (cap_n < 1024) cap[cap_n] = fifo_data;
                cap_n++;
            end
        end
    end

    always @(negedge clk) begin
        case (full_mode)
            1:       fifo_full <= ($urandom % 4 == 0);
            2:       fifo_full <= 1'b1;
            default: fifo_full <= 1'b0;
        endcase
    end

    function automatic logic [7:0] exp_byte(int k, int p, logic [31:0] h);
        if (p < 4)       return h[p*8 +: 8];
        else if (p < 28) return src_a[k][p-4];
        else if (p < 52) return src_b[k][p-28];
        else             return 8'hA5;
    endfunction

    function automatic string req_of(int p);
        if (p < 4)       return "R4";
        else if (p < 28) return "R2";
        else if (p < 52) return "R3";
        else             return "R5";
    endfunction

    // Feed one frame's segments with random gaps; optional surplus A byte (R11)
    task automatic feed(input int k, input bit extra);
        int ia = 0, ib = 0;
        bit sent_x = 0;
        while (ia < 24 || ib < 24 || (extra && !sent_x)) begin
            @(negedge clk);
            a_valid = 1'b0;
            b_valid = 1'b0;
            if (ia < 24 && ($urandom % 3 != 0)) begin
                a_valid = 1'b1;
                a_data  = src_a[k][ia];
            end else if (ia == 24 && extra && !sent_x) begin
                a_valid = 1'b1;
                a_data  = 8'hEE;
                sent_x  = 1;
            end
            if (ib < 24 && ($urandom % 3 != 0)) begin
                b_valid = 1'b1;
                b_data  = src_b[k][ib];
            end
            @(posedge clk);
            if (a_valid && ia < 24 && a_data == src_a[k][ia] && !(sent_x && a_data == 8'hEE && ia == 24)) ia++;
            if (b_valid && ib < 24) ib++;
        end
        @(negedge clk);
        a_valid = 1'b0;
        b_valid = 1'b0;
    endtask

    task automatic refill(input logic [31:0] h);
        @(negedge clk);
        hdr_in     = h;
        refill_req = 1'b1;
        @(negedge clk);
        refill_req = 1'b0;
        hdr_in     = ~h;   // later change must not reach the frame (R4)
    endtask

    task automatic collect(input int k, input int base, input logic [31:0] h);
        int t = 0;
        while (cap_n < base + 64 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(cap_n >= base + 64, "R6", "burst length", cap_n - base, 64);
        for (int p = 0; p < 64; p++)
            chk(cap[base+p] == exp_byte(k, p, h), req_of(p), $sformatf("frame%0d pos%0d", k, p),
                int'(cap[base+p]), int'(exp_byte(k, p, h)));
        repeat (5) @(negedge clk);
        chk(cap_n == base + 64, "R6", "no extra writes", cap_n - base, 64);
    endtask

    initial begin
        int base;
        logic [31:0] h;
        void'($urandom(32'd4711));
        for (int k = 0; k < NF; k++)
            for (int i = 0; i < 24; i++) begin
                src_a[k][i] = 8'($urandom);
                src_b[k][i] = 8'($urandom);
                if (src_a[k][i] == 8'hEE) src_a[k][i] = 8'h11;
            end

        repeat (3) @(negedge clk);
        chk(!fifo_wr && !not_ready, "R1", "outputs in reset", {fifo_wr, not_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fifo_wr && !not_ready, "R1", "outputs after reset", {fifo_wr, not_ready}, 0);

        // Frame 0, random stalls, frame 1 fed during the burst with a surplus byte (R8, R11)
        feed(0, 1'b0);
        repeat (3) @(negedge clk);
        base = cap_n; h = $urandom; full_mode = 1;
        refill(h);
        fork
            feed(1, 1'b1);
            collect(0, base, h);
        join
        full_mode = 0;

        // Frame 1; a request mid-burst must be ignored (R10)
        repeat (3) @(negedge clk);
        base = cap_n; h = $urandom;
        refill(h);
        fork
            feed(2, 1'b0);
            begin
                repeat (10) @(negedge clk);
                refill_req = 1'b1;
                @(negedge clk);
                refill_req = 1'b0;
            end
            collect(1, base, h);
        join
        chk(!not_ready, "R10", "flag after mid-burst request", int'(not_ready), 0);

        // Frame 2 with a long forced stall (R7)
        repeat (3) @(negedge clk);
        base = cap_n; h = $urandom;
        refill(h);
        fork
            feed(3, 1'b0);
            begin
                repeat (6) @(negedge clk);
                full_mode = 2;
                repeat (12) @(negedge clk);
                chk(cap_n - base <= 8, "R7", "writes during hold", cap_n - base, 8);
                full_mode = 0;
            end
            collect(2, base, h);
        join

        // Frames 3 to 5 with random stalls
        for (int k = 3; k < 6; k++) begin
            repeat (3) @(negedge clk);
            base = cap_n; h = $urandom; full_mode = 1;
            refill(h);
            fork
                if (k < 5) feed(k + 1, 1'b0);
                collect(k, base, h);
            join
            full_mode = 0;
        end

        // Nothing ready: request skipped and flag set (R9)
        repeat (3) @(negedge clk);
        base = cap_n;
        refill($urandom);
        repeat (10) @(negedge clk);
        chk(cap_n == base, "R9", "writes on skipped request", cap_n - base, 0);
        chk(not_ready, "R9", "flag set", int'(not_ready), 1);

        // Flag stays set across a normal frame (R9)
        feed(6, 1'b0);
        repeat (3) @(negedge clk);
        base = cap_n; h = $urandom;
        refill(h);
        collect(6, base, h);
        chk(not_ready, "R9", "flag sticky", int'(not_ready), 1);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule